// File: doc/BRIEF.md
# Synchronous Character Transmitter with Transparent Fill

This block is the transmit half of a character-oriented synchronous serial controller. The host writes characters into a one-entry holding register. The block moves each character into a shift register on a character boundary and sends it least significant bit first, one bit for each pulse of the bit-rate enable. Characters are 5 to 8 bits long, with an optional parity bit after the data. When no character is waiting at a boundary, the line is kept busy with idle fill taken from a programmable SYN register.

In transparent mode the same control bit stops acting as the parity enable and becomes a force-DLE request. When the request is set and a character is waiting, the programmable DLE value goes out first and the character follows directly, with nothing in between. Once a forced DLE has been sent in transparent mode, idle fill becomes a DLE-SYN pair. The block reports an empty holding register to the host through a status flag and a data-request strobe. While disabled, it holds the line at mark.

Top module: `sync_char_tx`

## Requirements
- R1: Each character leaves on `txd_o` LSB first, one bit per `bit_en_i` pulse, and the line shows the new bit from the cycle after that pulse. The data length comes from `len_sel_i`: 00 gives 8 bits, 01 gives 7, 10 gives 6 and 11 gives 5. Characters follow each other with no gap bits.
- R2: With `transp_i`=0 and `pe_fdle_i`=1, one parity bit follows the data bits of every character, fill included. The bit makes the count of ones odd when `par_odd_i`=1 and even when it is 0. With `pe_fdle_i`=0, or with `transp_i`=1, no parity bit is sent.
- R3: When no character is waiting at a boundary, one `syn_i` character is sent as fill. This holds with `transp_i`=0, and with `transp_i`=1 before any forced DLE has been sent.
- R4: With `transp_i`=1 and `pe_fdle_i`=1 at a boundary where a character is waiting, `dle_i` is sent first. The waiting character follows at the very next boundary, with no fill between the two.
- R5: After a forced DLE has been sent, idle fill in transparent mode is `dle_i` followed by `syn_i`, and the pair is never split by a host character.
- R6: The paired-fill state is lost when `transp_i` goes low or the transmitter is disabled. After that, fill is again a single SYN until the next forced DLE.
- R7: `thr_empty_o` is 1 while the transmitter is enabled and the holding register is empty. It goes to 0 in the cycle after a host write, and it returns to 1 in the cycle after the boundary that moves the character into the shift register.
- R8: While `tx_en_i`=0, `txd_o` is 1, `thr_empty_o` and `dreq_o` are 0, the holding register is cleared and host writes are ignored.
- R9: `dreq_o` is high exactly while the transmitter is enabled and the holding register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmitter enable |
| bit_en_i | input | 1 | One-cycle pulse per bit time |
| wr_i | input | 1 | Host write strobe for the holding register |
| wr_data_i | input | 8 | Host character |
| syn_i | input | 8 | SYN fill character |
| dle_i | input | 8 | DLE character |
| len_sel_i | input | 2 | Character length code |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| transp_i | input | 1 | Transparent mode |
| pe_fdle_i | input | 1 | Parity enable when not transparent, force DLE when transparent |
| txd_o | output | 1 | Serial data |
| thr_empty_o | output | 1 | Holding register empty |
| dreq_o | output | 1 | Data request to the host |

## Verification
The bench deframes the serial line and checks every character, fill included, against a queue of expected characters. These are the corner cases it targets:
- Transparent fill before any forced DLE. A design that arms the DLE-SYN fill too early sends a pair where a single SYN belongs.
- A forced DLE ahead of a host character. A design that can put fill between the DLE and the character shows an extra character in the stream.
- Paired fill after a DLE has been forced. A design that lets a host write split the pair sends the data character where the SYN should be.
- Clearing of the armed state by a transparency toggle or a disable. A design that keeps the state sends DLE-SYN where a single SYN is expected.
- Five- and seven-bit lengths with both parity senses, so a wrong mask or a wrong parity sense shows up as a wrong character.
- Writes while disabled. A design that latches such a write sends the stale character, or shows the register as full, after it is enabled.

// File: rtl/sync_char_tx_pkg.sv
package sync_char_tx_pkg;

  typedef enum logic [1:0] {
    SRC_SYN = 2'd0,
    SRC_DLE = 2'd1,
    SRC_THR = 2'd2
  } char_src_e;

endpackage

// File: rtl/sync_char_tx_hold.sv
module sync_char_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          take_i,
  output logic          full_o,
  output logic [DW-1:0] data_o,
  output logic          empty_o
);

  logic          full_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (!en_i) begin
      full_q <= 1'b0;
    end else if (wr_i) begin
      // a write in the take cycle refills the register
      full_q <= 1'b1;
      data_q <= wr_data_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o  = full_q;
  assign data_o  = data_q;
  assign empty_o = en_i & ~full_q;

  // R7
  wr_clears_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && wr_i |=> !empty_o);

  // R7
  take_sets_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && take_i && !wr_i |=> empty_o || !en_i);

endmodule

// File: rtl/sync_char_tx_seq.sv
module sync_char_tx_seq
  import sync_char_tx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      transp_i,
  input  logic      fdle_i,
  input  logic      thr_full_i,
  input  logic      boundary_i,
  output char_src_e src_o,
  output logic      take_o
);

  logic armed_q, dle_done_q, syn_pend_q;
  logic set_done, clr_done, set_arm, set_pend;

  always_comb begin
    src_o    = SRC_SYN;
    take_o   = 1'b0;
    set_done = 1'b0;
    clr_done = 1'b0;
    set_arm  = 1'b0;
    set_pend = 1'b0;
    if (boundary_i) begin
      if (syn_pend_q) begin
        src_o = SRC_SYN;
      end else if (thr_full_i && transp_i && fdle_i && !dle_done_q) begin
        src_o    = SRC_DLE;
        set_done = 1'b1;
        set_arm  = 1'b1;
      end else if (thr_full_i) begin
        src_o    = SRC_THR;
        take_o   = 1'b1;
        clr_done = 1'b1;
      end else if (transp_i && armed_q) begin
        src_o    = SRC_DLE;
        set_pend = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      dle_done_q <= 1'b0;
      syn_pend_q <= 1'b0;
    end else if (!en_i) begin
      armed_q    <= 1'b0;
      dle_done_q <= 1'b0;
      syn_pend_q <= 1'b0;
    end else begin
      if (set_pend)        syn_pend_q <= 1'b1;
      else if (boundary_i) syn_pend_q <= 1'b0;
      if (!transp_i)       armed_q <= 1'b0;
      else if (set_arm)    armed_q <= 1'b1;
      if (!transp_i)       dle_done_q <= 1'b0;
      else if (set_done)   dle_done_q <= 1'b1;
      else if (clr_done)   dle_done_q <= 1'b0;
    end
  end

  // R4: a forced DLE keeps its character waiting in the holding register
  fdle_holds_char_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && dle_done_q |-> thr_full_i);

  // R6
  arm_needs_transp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(transp_i));

endmodule

// File: rtl/sync_char_tx_frame.sv
module sync_char_tx_frame
  import sync_char_tx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 4
) (
  input  char_src_e        src_i,
  input  logic [DW-1:0]    thr_data_i,
  input  logic [DW-1:0]    syn_i,
  input  logic [DW-1:0]    dle_i,
  input  logic [1:0]       len_sel_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  output logic [DW:0]      word_o,
  output logic [CNT_W-1:0] nbits_o
);

  logic [DW-1:0]    raw, mask, data;
  logic [CNT_W-1:0] ndata;

  assign ndata = CNT_W'(DW) - CNT_W'(len_sel_i);

  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign mask[i] = (CNT_W'(i) < ndata);
  end

  always_comb begin
    unique case (src_i)
      SRC_THR: raw = thr_data_i;
      SRC_DLE: raw = dle_i;
      default: raw = syn_i;
    endcase
    data   = raw & mask;
    word_o = {1'b0, data};
    if (par_en_i) word_o[ndata] = (^data) ^ par_odd_i;
    nbits_o = ndata + CNT_W'(par_en_i);
  end

endmodule

// File: rtl/sync_char_tx_shift.sv
module sync_char_tx_shift #(
  parameter int DW    = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bit_en_i,
  input  logic [DW:0]      word_i,
  input  logic [CNT_W-1:0] nbits_i,
  output logic             boundary_o,
  output logic             txd_o
);

  logic [DW:0]      sreg_q;
  logic [CNT_W-1:0] remain_q;

  assign boundary_o = en_i & bit_en_i & (remain_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txd_o    <= 1'b1;
      sreg_q   <= '0;
      remain_q <= '0;
    end else if (!en_i) begin
      txd_o    <= 1'b1;
      sreg_q   <= '0;
      remain_q <= '0;
    end else if (bit_en_i) begin
      if (boundary_o) begin
        txd_o    <= word_i[0];
        sreg_q   <= word_i >> 1;
        remain_q <= nbits_i;
      end else begin
        txd_o    <= sreg_q[0];
        sreg_q   <= sreg_q >> 1;
        remain_q <= remain_q - CNT_W'(1);
      end
    end
  end

  // R8
  mark_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> txd_o);

  // R1
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remain_q <= CNT_W'(DW + 1));

endmodule

// File: rtl/sync_char_tx.sv
module sync_char_tx
  import sync_char_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_en_i,
  input  logic          bit_en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [DW-1:0] syn_i,
  input  logic [DW-1:0] dle_i,
  input  logic [1:0]    len_sel_i,
  input  logic          par_odd_i,
  input  logic          transp_i,
  input  logic          pe_fdle_i,
  output logic          txd_o,
  output logic          thr_empty_o,
  output logic          dreq_o
);

  localparam int CNT_W = $clog2(DW + 2);

  logic             thr_full, take, boundary;
  logic [DW-1:0]    thr_data;
  logic [DW:0]      word;
  logic [CNT_W-1:0] nbits;
  char_src_e        src;

  sync_char_tx_hold #(.DW(DW)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (tx_en_i),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .full_o    (thr_full),
    .data_o    (thr_data),
    .empty_o   (thr_empty_o)
  );

  sync_char_tx_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (tx_en_i),
    .transp_i   (transp_i),
    .fdle_i     (pe_fdle_i),
    .thr_full_i (thr_full),
    .boundary_i (boundary),
    .src_o      (src),
    .take_o     (take)
  );

  sync_char_tx_frame #(.DW(DW), .CNT_W(CNT_W)) u_frame (
    .src_i      (src),
    .thr_data_i (thr_data),
    .syn_i      (syn_i),
    .dle_i      (dle_i),
    .len_sel_i  (len_sel_i),
    .par_en_i   (pe_fdle_i & ~transp_i),
    .par_odd_i  (par_odd_i),
    .word_o     (word),
    .nbits_o    (nbits)
  );

  sync_char_tx_shift #(.DW(DW), .CNT_W(CNT_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (tx_en_i),
    .bit_en_i   (bit_en_i),
    .word_i     (word),
    .nbits_i    (nbits),
    .boundary_o (boundary),
    .txd_o      (txd_o)
  );

  assign dreq_o = thr_empty_o;

  // R9
  dreq_drops_on_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_i && wr_i |=> !dreq_o);

endmodule

// File: tb/sync_char_tx_test.sv
module sync_char_tx_test;

  localparam logic [7:0] SYN = 8'h16;
  localparam logic [7:0] DLE = 8'h90;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, bit_en = 1'b0, wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] len_sel = 2'b00;
  logic       par_odd = 1'b0, transp = 1'b0, pe_fdle = 1'b0;
  logic       txd, thr_empty, dreq;

  int checks = 0, fails = 0, rcnt = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  sync_char_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .bit_en_i(bit_en),
    .wr_i(wr), .wr_data_i(wr_data), .syn_i(SYN), .dle_i(DLE),
    .len_sel_i(len_sel), .par_odd_i(par_odd), .transp_i(transp),
    .pe_fdle_i(pe_fdle), .txd_o(txd), .thr_empty_o(thr_empty), .dreq_o(dreq)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int dlen();
    return 8 - int'(len_sel);
  endfunction

  // bit-rate enable: one pulse every 4 cycles while enabled
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      if (!tx_en) begin div = 0; bit_en = 1'b0; end
      else begin
        div++;
        bit_en = (div == 4);
        if (div == 4) div = 0;
      end
    end
  end

  // monitor: deframe serial stream and compare against the queue
  initial begin
    int nb = 0;
    logic [8:0] acc = '0;
    forever begin
      @(posedge clk);
      if (!tx_en) begin nb = 0; acc = '0; end
      else if (bit_en) begin
        @(negedge clk);
        acc[nb] = txd;
        nb++;
        if (nb == dlen() + int'(pe_fdle && !transp)) begin
          logic [7:0] m, e, got;
          logic [8:0] ew;
          string t;
          m = 8'hFF >> (8 - dlen());
          got = acc[7:0] & m;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R1", "unexpected char", int'(got), 0);
          end else begin
            e = exp_q.pop_front() & m;
            t = tag_q.pop_front();
            ew = {1'b0, e};
            if (pe_fdle && !transp) ew[dlen()] = (^e) ^ par_odd;
            chk(acc == ew, t, "char", int'(acc), int'(ew));
          end
          rcnt++;
          nb = 0;
          acc = '0;
        end
      end
    end
  end

  task automatic push(logic [7:0] c, string t);
    exp_q.push_back(c);
    tag_q.push_back(t);
  endtask

  task automatic wait_empty();
    forever begin @(negedge clk); if (thr_empty) break; end
  endtask

  task automatic send(logic [7:0] c, string t);
    wait_empty();
    wr = 1'b1; wr_data = c;
    push(c, t);
    @(negedge clk);
    wr = 1'b0;
    chk(!thr_empty, "R7", "empty after write", int'(thr_empty), 0);
    chk(!dreq, "R9", "dreq after write", int'(dreq), 0);
  endtask

  task automatic wait_rx(int target);
    while (rcnt < target) @(negedge clk);
  endtask

  // n fill characters after the character last written
  task automatic gap(int n, logic [7:0] f0, logic [7:0] f1, string t);
    int base;
    for (int i = 0; i < n; i++) push((i % 2 == 0) ? f0 : f1, t);
    wait_empty();
    base = rcnt;
    wait_rx(base + 1 + n);
  endtask

  task automatic fill_from_enable(int n, string t);
    int base;
    base = rcnt;
    for (int i = 0; i < n; i++) push(SYN, t);
    wait_rx(base + n);
  endtask

  task automatic configure(logic [1:0] l, logic pe, logic odd, logic tp);
    @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    len_sel = l; pe_fdle = pe; par_odd = odd; transp = tp;
    @(negedge clk);
  endtask

  task automatic enable();
    tx_en = 1'b1;
    @(negedge clk);
    chk(thr_empty, "R7", "empty after enable", int'(thr_empty), 1);
    chk(dreq, "R9", "dreq after enable", int'(dreq), 1);
  endtask

  task automatic end_phase();
    int base;
    wait_empty();
    base = rcnt;
    wait_rx(base + 1);
    tx_en = 1'b0;
    chk(exp_q.size() == 0, "R1", "queue left", exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(txd, "R8", "txd in reset", int'(txd), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd && !thr_empty && !dreq, "R8", "idle after reset",
        {txd, thr_empty, dreq}, 3'b100);

    // 8-bit, no parity, single-SYN fill
    configure(2'b00, 1'b0, 1'b0, 1'b0);
    enable();
    send(8'hA5, "R1"); send(8'h3C, "R1");
    gap(2, SYN, SYN, "R3");
    send(8'h81, "R1");
    end_phase();

    // 5-bit, even parity
    configure(2'b11, 1'b1, 1'b0, 1'b0);
    enable();
    send(8'h1F, "R2"); send(8'h0B, "R2");
    gap(1, SYN, SYN, "R2");
    send(8'h12, "R2");
    end_phase();

    // 7-bit, odd parity
    configure(2'b01, 1'b1, 1'b1, 1'b0);
    enable();
    send(8'h7F, "R2"); send(8'h40, "R2");
    gap(1, SYN, SYN, "R2");
    send(8'h00, "R2");
    end_phase();

    // 6-bit, no parity
    configure(2'b10, 1'b0, 1'b0, 1'b0);
    enable();
    send(8'h2A, "R1"); send(8'h15, "R1"); send(8'h3F, "R1");
    end_phase();

    // writes while disabled are ignored
    configure(2'b00, 1'b0, 1'b0, 1'b0);
    wr = 1'b1; wr_data = 8'h55;
    @(negedge clk);
    wr = 1'b0;
    chk(!thr_empty && !dreq && txd, "R8", "disabled write",
        {txd, thr_empty, dreq}, 3'b100);
    enable();
    fill_from_enable(1, "R8");
    send(8'h66, "R8");
    end_phase();

    // transparency
    configure(2'b00, 1'b0, 1'b0, 1'b1);
    enable();
    send(8'h10, "R3");
    gap(1, SYN, SYN, "R3");
    pe_fdle = 1'b1;
    push(DLE, "R4");
    send(8'h20, "R4");
    wait_empty();
    pe_fdle = 1'b0;
    gap(2, DLE, SYN, "R5");
    send(8'h30, "R5");
    gap(4, DLE, SYN, "R5");
    send(8'h31, "R5");
    wait_empty();
    transp = 1'b0;
    @(negedge clk);
    transp = 1'b1;
    gap(1, SYN, SYN, "R6");
    send(8'h32, "R6");
    end_phase();

    // disable clears the armed state
    configure(2'b00, 1'b1, 1'b0, 1'b1);
    enable();
    push(DLE, "R4");
    send(8'h44, "R4");
    wait_empty();
    pe_fdle = 1'b0;
    gap(2, DLE, SYN, "R5");
    send(8'h45, "R5");
    end_phase();
    configure(2'b00, 1'b0, 1'b0, 1'b1);
    enable();
    fill_from_enable(1, "R6");
    send(8'h46, "R6");
    end_phase();

    @(negedge clk);
    chk(txd, "R8", "txd after disable", int'(txd), 1);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R1: watchdog actual %0d expected %0d", rcnt, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule